// File: doc/BRIEF.md
# Fetch Steering and Misprediction Flush Controller

This block owns the fetch program counter of an in-order five-stage pipeline. Each cycle it looks at the instruction being fetched and predicts the next fetch address. The predecoder marks each branch or jump and supplies its target. Conditional branches that point backwards (target below the current PC) are predicted taken. Forward conditional branches are predicted not taken. Unconditional jumps are always predicted taken. Every other instruction advances by four, using an adder local to the fetch stage. The prediction leaves the block as a one-bit tag and a predicted next PC, which travel down the pipeline with the instruction.

When the instruction reaches execute, the pipeline returns its real outcome: valid, taken, resolved target and PC, together with the tag and predicted next PC it carried. The block works out the correct next address from these. If it disagrees with the prediction, the block raises both kill outputs in that same cycle. These turn the instructions held in the fetch and decode pipeline registers into bubbles. On the following cycle the PC holds the corrected address. A confirmed prediction produces no action at all.

A small state machine guards the recovery. In state RUN the pipeline flows. HOLD is entered whenever the global stall is high, and the PC is frozen there. REFILL is entered from RUN or HOLD on a flush. It lasts `EX_DEPTH` unstalled cycles, during which resolutions are ignored because they can only come from killed slots. REFILL returns to RUN once that count expires. RUN goes to HOLD on stall, and HOLD returns to RUN when the stall drops.

Top module: `fetch_steer`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `f_pc_o` equals `RESET_PC` and both kill outputs are low.
- R2: A fetched instruction with `f_is_ctl_i`=0 yields `f_pred_taken_o`=0 and `f_pred_npc_o`=PC+4, and with no stall and no flush the PC becomes PC+4 on the next cycle.
- R3: A conditional control transfer (`f_is_ctl_i`=1, `f_is_jump_i`=0) whose target is below the PC (unsigned) is predicted taken: tag 1, next PC = target. A target at or above the PC is predicted not taken: tag 0, next PC = PC+4.
- R4: An unconditional jump (`f_is_ctl_i`=1, `f_is_jump_i`=1) is predicted taken whatever its target's direction, and the next fetch is its target.
- R5: A valid resolution whose outcome matches its prediction raises no kill and leaves the PC following the fetch prediction.
- R6: A valid resolution is a misprediction when `x_taken_i` differs from `x_pred_taken_i`, or when the correct next address (`x_target_i` if taken, else `x_pc_i`+4) differs from `x_pred_npc_i`.
- R7: In the cycle a misprediction is accepted, `kill_fetch_o` and `kill_decode_o` are both 1, and in the next cycle `f_pc_o` equals the correct next address.
- R8: A redirect from execute takes priority over the fetch-stage prediction made in the same cycle.
- R9: While `stall_i`=1 the PC holds its value, except that an accepted misprediction still redirects it.
- R10: For the `EX_DEPTH` unstalled cycles following a flush (state REFILL), resolutions are ignored and no kill is raised. A mismatching resolution after that window flushes again.
- R11: Across a run without stalls, each misprediction costs exactly `EX_DEPTH` bubble cycles at execute, and each correct prediction costs none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Global pipeline stall |
| f_is_ctl_i | input | 1 | Predecode: the fetched word is a branch or jump |
| f_is_jump_i | input | 1 | Predecode: the control transfer is unconditional |
| f_target_i | input | AW | Target address of the fetched control transfer |
| f_pc_o | output | AW | Current fetch PC |
| f_pred_taken_o | output | 1 | Prediction tag to carry with the instruction |
| f_pred_npc_o | output | AW | Predicted next PC to carry with the instruction |
| x_valid_i | input | 1 | Execute holds a real instruction to resolve |
| x_pc_i | input | AW | PC of the instruction in execute |
| x_taken_i | input | 1 | Resolved outcome: control transfer taken |
| x_target_i | input | AW | Resolved target address |
| x_pred_taken_i | input | 1 | Prediction tag carried to execute |
| x_pred_npc_i | input | AW | Predicted next PC carried to execute |
| kill_fetch_o | output | 1 | Invalidate the fetch/decode pipeline register |
| kill_decode_o | output | 1 | Invalidate the decode/execute pipeline register |

## Verification
The bench builds the block with `AW`=32, `EX_DEPTH`=2 and `RESET_PC`=0x100. With a two-slot window, both edges of REFILL can be reached in a few cycles: the quiet cycles and the first cycle after the window ends. The bench also models the fetch and decode slots around the block and runs a short program with one mispredicted forward branch, one mispredicted backward branch and two correct predictions. With this depth the expected penalty is exactly four bubbles. Stall is exercised on its own and together with a redirect, since the freeze and the redirect pull the PC in opposite directions.

// File: rtl/steer_pkg.sv
package steer_pkg;

    // Recovery controller states
    typedef enum logic [1:0] {
        S_RUN    = 2'd0,
        S_HOLD   = 2'd1,
        S_REFILL = 2'd2
    } steer_state_e;

    // Byte distance between sequential instruction words
    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/steer_predict.sv
module steer_predict
    import steer_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] pc_i,
    input  logic          is_ctl_i,
    input  logic          is_jump_i,
    input  logic [AW-1:0] target_i,
    output logic          pred_taken_o,
    output logic [AW-1:0] pred_npc_o
);

    logic [AW-1:0] seq_pc;
    logic          points_back;

    // Fetch-local incrementer, independent of the execute ALU
    assign seq_pc = pc_i + AW'(WORD_BYTES);

    // Backward-taken / forward-not-taken: a negative offset means target < pc
    assign points_back = (target_i < pc_i);

    always_comb begin
        pred_taken_o = 1'b0;
        if (is_ctl_i) begin
            pred_taken_o = is_jump_i | points_back;
        end
        pred_npc_o = pred_taken_o ? target_i : seq_pc;
    end

endmodule

// File: rtl/steer_resolve.sv
module steer_resolve
    import steer_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          valid_i,
    input  logic [AW-1:0] pc_i,
    input  logic          taken_i,
    input  logic [AW-1:0] target_i,
    input  logic          tag_i,
    input  logic [AW-1:0] pred_npc_i,
    output logic          miss_o,
    output logic [AW-1:0] fix_npc_o
);

    logic [AW-1:0] fall_through;
    logic          dir_wrong;
    logic          addr_wrong;

    assign fall_through = pc_i + AW'(WORD_BYTES);
    assign fix_npc_o    = taken_i ? target_i : fall_through;
    assign dir_wrong    = (taken_i != tag_i);
    assign addr_wrong   = (fix_npc_o != pred_npc_i);
    assign miss_o       = valid_i & (dir_wrong | addr_wrong);

endmodule

// File: rtl/steer_fsm.sv
module steer_fsm
    import steer_pkg::*;
#(
    parameter int unsigned EX_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall_i,
    input  logic miss_i,
    output logic flush_o
);

    localparam int unsigned CW = (EX_DEPTH < 2) ? 1 : $clog2(EX_DEPTH + 1);
    localparam logic [CW-1:0] FILL_LOAD = CW'(EX_DEPTH);

    steer_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_RUN: begin
                if (miss_i) begin
                    state_d = S_REFILL;
                    cnt_d   = FILL_LOAD;
                end else if (stall_i) begin
                    state_d = S_HOLD;
                end
            end
            S_HOLD: begin
                if (miss_i) begin
                    state_d = S_REFILL;
                    cnt_d   = FILL_LOAD;
                end else if (!stall_i) begin
                    state_d = S_RUN;
                end
            end
            S_REFILL: begin
                if (!stall_i) begin
                    if (cnt_q <= CW'(1)) begin
                        state_d = S_RUN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
            end
            default: begin
                state_d = S_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        flush_o = 1'b0;
        unique case (state_q)
            S_RUN, S_HOLD: flush_o = miss_i;
            S_REFILL:      flush_o = 1'b0;
            default:       flush_o = 1'b0;
        endcase
    end

    // R10
    refill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REFILL) |-> !flush_o);

    // R10
    refill_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> (state_q == S_REFILL));

    // R9
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && stall_i && !miss_i) |=> (state_q == S_HOLD));

endmodule

// File: rtl/fetch_steer.sv
module fetch_steer
    import steer_pkg::*;
#(
    parameter int unsigned   AW       = 32,
    parameter int unsigned   EX_DEPTH = 2,
    parameter logic [AW-1:0] RESET_PC = 'h100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall_i,
    input  logic          f_is_ctl_i,
    input  logic          f_is_jump_i,
    input  logic [AW-1:0] f_target_i,
    output logic [AW-1:0] f_pc_o,
    output logic          f_pred_taken_o,
    output logic [AW-1:0] f_pred_npc_o,
    input  logic          x_valid_i,
    input  logic [AW-1:0] x_pc_i,
    input  logic          x_taken_i,
    input  logic [AW-1:0] x_target_i,
    input  logic          x_pred_taken_i,
    input  logic [AW-1:0] x_pred_npc_i,
    output logic          kill_fetch_o,
    output logic          kill_decode_o
);

    logic [AW-1:0] pc_q;
    logic          miss;
    logic [AW-1:0] fix_npc;
    logic          flush;

    steer_predict #(.AW(AW)) u_predict (
        .pc_i         (pc_q),
        .is_ctl_i     (f_is_ctl_i),
        .is_jump_i    (f_is_jump_i),
        .target_i     (f_target_i),
        .pred_taken_o (f_pred_taken_o),
        .pred_npc_o   (f_pred_npc_o)
    );

    steer_resolve #(.AW(AW)) u_resolve (
        .valid_i    (x_valid_i),
        .pc_i       (x_pc_i),
        .taken_i    (x_taken_i),
        .target_i   (x_target_i),
        .tag_i      (x_pred_taken_i),
        .pred_npc_i (x_pred_npc_i),
        .miss_o     (miss),
        .fix_npc_o  (fix_npc)
    );

    steer_fsm #(.EX_DEPTH(EX_DEPTH)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall_i (stall_i),
        .miss_i  (miss),
        .flush_o (flush)
    );

    // PC register: redirect beats stall, stall beats prediction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else if (flush) begin
            pc_q <= fix_npc;
        end else if (!stall_i) begin
            pc_q <= f_pred_npc_o;
        end
    end

    assign f_pc_o        = pc_q;
    assign kill_fetch_o  = flush;
    assign kill_decode_o = flush;

    // R7
    redirect_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_fetch_o |=> (f_pc_o == $past(fix_npc)));

    // R7
    kill_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_decode_o |-> x_valid_i);

    // R9
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !kill_fetch_o) |=> $stable(f_pc_o));

    // R5
    follow_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !kill_fetch_o) |=> (f_pc_o == $past(f_pred_npc_o)));

    // R4
    jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_is_ctl_i && f_is_jump_i) |-> (f_pred_taken_o && f_pred_npc_o == f_target_i));

endmodule

// File: tb/test_fetch_steer.sv
module test_fetch_steer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        f_is_ctl = 1'b0;
    logic        f_is_jump = 1'b0;
    logic [31:0] f_target = '0;
    logic [31:0] f_pc;
    logic        f_pred_taken;
    logic [31:0] f_pred_npc;
    logic        x_valid = 1'b0;
    logic [31:0] x_pc = '0;
    logic        x_taken = 1'b0;
    logic [31:0] x_target = '0;
    logic        x_pred_taken = 1'b0;
    logic [31:0] x_pred_npc = '0;
    logic        kill_f;
    logic        kill_d;

    int n_checks = 0;
    int n_fail   = 0;

    localparam int DEPTH = 2;

    always #2.5 clk = ~clk;

    fetch_steer #(.AW(32), .EX_DEPTH(DEPTH), .RESET_PC(32'h100)) i_fetch_steer (
        .clk            (clk),
        .rst_n          (rst_n),
        .stall_i        (stall),
        .f_is_ctl_i     (f_is_ctl),
        .f_is_jump_i    (f_is_jump),
        .f_target_i     (f_target),
        .f_pc_o         (f_pc),
        .f_pred_taken_o (f_pred_taken),
        .f_pred_npc_o   (f_pred_npc),
        .x_valid_i      (x_valid),
        .x_pc_i         (x_pc),
        .x_taken_i      (x_taken),
        .x_target_i     (x_target),
        .x_pred_taken_i (x_pred_taken),
        .x_pred_npc_i   (x_pred_npc),
        .kill_fetch_o   (kill_f),
        .kill_decode_o  (kill_d)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_cyc();
        @(negedge clk);
    endtask

    task automatic set_fetch(input logic c, input logic j, input logic [31:0] t);
        f_is_ctl = c; f_is_jump = j; f_target = t;
    endtask

    task automatic set_exec(input logic v, input logic [31:0] pc, input logic tk,
                            input logic [31:0] tg, input logic tag, input logic [31:0] npc);
        x_valid = v; x_pc = pc; x_taken = tk; x_target = tg; x_pred_taken = tag; x_pred_npc = npc;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        set_fetch(0, 0, 0);
        set_exec(0, 0, 0, 0, 0, 0);
        stall = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #1;
        chk("R1 pc in reset", f_pc, 32'h100);
        chk("R1 kill in reset", {31'd0, kill_f | kill_d}, 0);
        do_reset();
        #1;
        chk("R1 pc after reset", f_pc, 32'h100);
        chk("R1 kill after reset", {31'd0, kill_f | kill_d}, 0);
    endtask

    task automatic t_seq();
        set_fetch(0, 0, 32'h0);
        #1;
        chk("R2 tag", {31'd0, f_pred_taken}, 0);
        chk("R2 npc", f_pred_npc, 32'h104);
        next_cyc();
        chk("R2 pc+4", f_pc, 32'h104);
    endtask

    task automatic t_btfn();
        set_fetch(1, 0, 32'h80);
        #1;
        chk("R3 backward tag", {31'd0, f_pred_taken}, 1);
        next_cyc();
        chk("R3 backward next", f_pc, 32'h80);
        set_fetch(1, 0, 32'h200);
        #1;
        chk("R3 forward tag", {31'd0, f_pred_taken}, 0);
        chk("R3 forward npc", f_pred_npc, 32'h84);
        next_cyc();
        chk("R3 forward next", f_pc, 32'h84);
    endtask

    task automatic t_jump();
        set_fetch(1, 1, 32'h300);
        #1;
        chk("R4 jump tag", {31'd0, f_pred_taken}, 1);
        next_cyc();
        chk("R4 jump next", f_pc, 32'h300);
        set_fetch(0, 0, 0);
    endtask

    task automatic t_correct();
        set_exec(1, 32'h1000, 1, 32'h2000, 1, 32'h2000);
        #1;
        chk("R5 taken correct kill", {31'd0, kill_f}, 0);
        next_cyc();
        chk("R5 taken correct pc", f_pc, 32'h304);
        set_exec(1, 32'h1000, 0, 32'h2000, 0, 32'h1004);
        #1;
        chk("R5 not-taken correct kill", {31'd0, kill_d}, 0);
        next_cyc();
        chk("R5 not-taken correct pc", f_pc, 32'h308);
        set_exec(0, 0, 0, 0, 0, 0);
    endtask

    task automatic drain();
        set_exec(0, 0, 0, 0, 0, 0);
        repeat (DEPTH + 1) next_cyc();
    endtask

    task automatic t_miss_refill();
        set_exec(1, 32'h1000, 1, 32'h2000, 0, 32'h1004);
        #1;
        chk("R7 kill fetch", {31'd0, kill_f}, 1);
        chk("R7 kill decode", {31'd0, kill_d}, 1);
        next_cyc();
        chk("R7 redirect pc", f_pc, 32'h2000);
        chk("R10 refill cycle 1 quiet", {31'd0, kill_f}, 0);
        next_cyc();
        chk("R10 refill cycle 2 quiet", {31'd0, kill_f}, 0);
        chk("R10 fetch flows in refill", f_pc, 32'h2004);
        next_cyc();
        chk("R10 window over kills", {31'd0, kill_f}, 1);
        next_cyc();
        chk("R10 second redirect", f_pc, 32'h2000);
        drain();
    endtask

    task automatic t_miss_kinds();
        set_exec(1, 32'h1000, 1, 32'h2400, 1, 32'h2000);
        #1;
        chk("R6 target mismatch kills", {31'd0, kill_f}, 1);
        next_cyc();
        chk("R6 target mismatch redirect", f_pc, 32'h2400);
        drain();
        set_exec(1, 32'h1000, 0, 32'h3000, 1, 32'h3000);
        #1;
        chk("R6 direction mismatch kills", {31'd0, kill_f}, 1);
        next_cyc();
        chk("R6 not-taken redirect to pc+4", f_pc, 32'h1004);
        drain();
    endtask

    task automatic t_priority();
        set_fetch(1, 1, 32'h500);
        set_exec(1, 32'h1000, 1, 32'h2000, 0, 32'h1004);
        next_cyc();
        chk("R8 redirect beats prediction", f_pc, 32'h2000);
        set_fetch(0, 0, 0);
        drain();
    endtask

    task automatic t_stall();
        logic [31:0] held;
        held = f_pc;
        stall = 1'b1;
        set_fetch(1, 1, 32'h500);
        next_cyc();
        chk("R9 stall holds pc 1", f_pc, held);
        next_cyc();
        chk("R9 stall holds pc 2", f_pc, held);
        set_exec(1, 32'h1000, 1, 32'h2800, 0, 32'h1004);
        #1;
        chk("R9 kill under stall", {31'd0, kill_f}, 1);
        next_cyc();
        chk("R9 redirect under stall", f_pc, 32'h2800);
        set_exec(0, 0, 0, 0, 0, 0);
        next_cyc();
        chk("R9 stall holds redirected pc", f_pc, 32'h2800);
        stall = 1'b0;
        set_fetch(0, 0, 0);
        drain();
    endtask

    typedef struct packed {
        logic        v;
        logic [31:0] pc;
        logic        tk;
        logic [31:0] tg;
        logic        tag;
        logic [31:0] npc;
    } slot_t;

    task automatic prog(input logic [31:0] pc, output logic c, output logic j,
                        output logic tk, output logic [31:0] tg);
        c = 0; j = 0; tk = 0; tg = 0;
        case (pc)
            32'h104: begin c = 1; tg = 32'h120; tk = 1; end
            32'h120: begin c = 1; j = 1; tg = 32'h140; tk = 1; end
            32'h140: begin c = 1; tg = 32'h100; tk = 0; end
            32'h144: begin c = 1; tg = 32'h160; tk = 0; end
            default: ;
        endcase
    endtask

    task automatic t_program();
        slot_t id_s, ex_s, if_s, id_n, ex_n;
        logic  c, j, tk;
        logic [31:0] tg;
        int span, retired, kills, guard;
        logic started, done;
        id_s = '0; ex_s = '0;
        span = 0; retired = 0; kills = 0; guard = 0;
        started = 0; done = 0;
        do_reset();
        while (!done && guard < 100) begin
            guard++;
            prog(f_pc, c, j, tk, tg);
            set_fetch(c, j, tg);
            #1;
            if (ex_s.v && ex_s.pc == 32'h100) started = 1;
            if (started) begin
                span++;
                if (ex_s.v) retired++;
                if (ex_s.v && ex_s.pc == 32'h150) done = 1;
            end
            if (kill_f) kills++;
            if_s = '{1'b1, f_pc, tk, tg, f_pred_taken, f_pred_npc};
            id_n = kill_f ? '0 : if_s;
            ex_n = kill_d ? '0 : id_s;
            @(posedge clk);
            #1;
            id_s = id_n;
            ex_s = ex_n;
            set_exec(ex_s.v, ex_s.pc, ex_s.tk, ex_s.tg, ex_s.tag, ex_s.npc);
            @(negedge clk);
        end
        chk("R11 program completes", {31'd0, done}, 1);
        chk("R11 retired count", retired, 8);
        chk("R11 mispredict count", kills, 2);
        chk("R11 bubbles equal 2*EX_DEPTH", span - retired, 2 * DEPTH);
        set_exec(0, 0, 0, 0, 0, 0);
        set_fetch(0, 0, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_seq();
        t_btfn();
        t_jump();
        t_correct();
        t_miss_refill();
        t_miss_kinds();
        t_priority();
        t_stall();
        t_program();
        summary();
    end

endmodule